// File: doc/BRIEF.md
# Panel Register Write SPI Sequencer

This block turns register write requests for a display controller into SPI traffic. A request carries an 8-bit register address and a 16-bit value. The block accepts it through a valid/ready handshake and emits two chip-select frames of three bytes each. The first is an index frame, lead byte 0x74, then 0x00, then the address. The second is a data frame, lead byte 0x76, then the value's high byte, then its low byte. Bits leave most significant first in SPI mode 0. The SPI clock comes from the system clock through a parameterised half-period divider. Chip-select stays high for at least one SPI clock period between frames.

Besides plain writes, the same handshake accepts three power operations. Each one expands into an ordered series of register writes, built from the shutdown-control register (0x11, bit 0: 1 = shut down, 0 = on) and the driver-output-control register (0x01). The driver-output value is built from the default 0x2AEF. The bits covered by the parameter `MODE_MASK` are cleared in it and then filled from the request's mode word. `done` pulses once when the whole operation has finished.

The controller FSM has four states. IDLE accepts a request and moves to LOAD. LOAD starts the index frame of the current step and moves to INDEX. INDEX waits for the end of that frame, starts the data frame, and moves to DATA. DATA waits for the end of the data frame. If more steps remain, it moves back to LOAD. After the final step it raises `done` and returns to IDLE.

The frame engine also has named states:
- FIDLE: waiting for a frame to start.
- FLOW and FHIGH: the two halves of each SPI clock period.
- FHOLD: a half period with chip-select still low after the last bit.
- FGAP: one full SPI period with chip-select high, after which the engine pulses its frame-done signal.

Top module: `panel_spi_regwr`

## Requirements
- R1: Every register write starts with an index frame of exactly 24 bits: 0x74, 0x00, then the register address.
- R2: The index frame is followed by a data frame of exactly 24 bits: 0x76, the value's high byte, then its low byte. Chip-select is released between the two frames, and a new frame starts only when the frame engine is idle.
- R3: Timing follows SPI mode 0 with bits sent most significant first. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` does not change while `spi_sck` is high.
- R4: Between any two frames, `spi_cs_n` stays high for at least 2*HALF_DIV clock cycles (one SPI clock period).
- R5: `op_ready` is high only in IDLE, and `busy` is its inverse. A request presented while busy is ignored: it produces no frames and no `done`.
- R6: `done` is a single-cycle pulse, given exactly once per accepted operation, after the final data frame, with `spi_cs_n` high.
- R7: Operation kind 2'b00 (plain write) issues one write of `op_reg` with `op_value`.
- R8: Operation kind 2'b01 (power-up) writes register 0x11 with 0x0000, then register 0x01 with the mode value.
- R9: Operation kind 2'b10 (resume) writes register 0x01 with the mode value, then register 0x11 with 0x0000.
- R10: Operation kind 2'b11 (power-down) writes register 0x11 with 0x0001.
- R11: The mode value is (0x2AEF & ~MODE_MASK) | (op_mode & MODE_MASK), using `op_mode` as captured when the request is accepted. With the default mask 0x3C00 this gives 0x02EF | (op_mode & 0x3C00).
- R12: After reset, `spi_cs_n` is high, `spi_sck` is low, `busy` is low, `op_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Request accepted when high together with op_valid |
| op_kind | input | 2 | 00 write, 01 power-up, 10 resume, 11 power-down |
| op_reg | input | 8 | Register address for a plain write |
| op_value | input | 16 | Register value for a plain write |
| op_mode | input | 16 | Mode bits merged into the driver-output value |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI serial data out |
| spi_cs_n | output | 1 | Active-low chip-select |

## Verification
The assertions check the following on every cycle:
- The SPI clock idles low while chip-select is high.
- MOSI holds still while the SPI clock is high.
- A frame is started only when the frame engine is idle.
- An accepted request makes the block busy.
- `done` is a single pulse that occurs with chip-select high.

Only the bench's scenarios can show that the bytes of each frame and the order of frames within each power operation are correct. The scenarios also cover merging the mode bits into the driver-output value, the minimum deselect gap, and that a request offered while busy leaves no trace on the bus.

// File: rtl/panel_spi_pkg.sv
package panel_spi_pkg;

    typedef enum logic [1:0] {
        OP_WRITE      = 2'b00,
        OP_POWER_UP   = 2'b01,
        OP_RESUME     = 2'b10,
        OP_POWER_DOWN = 2'b11
    } op_kind_t;

    localparam logic [7:0]  LEAD_INDEX = 8'h74;
    localparam logic [7:0]  LEAD_DATA  = 8'h76;
    localparam logic [7:0]  REG_SHUT   = 8'h11;
    localparam logic [7:0]  REG_DRVOUT = 8'h01;
    localparam logic [15:0] SHUT_ON    = 16'h0000;
    localparam logic [15:0] SHUT_OFF   = 16'h0001;
    localparam logic [15:0] DRV_BASE   = 16'h2AEF;

endpackage

// File: rtl/panel_spi_frame.sv
module panel_spi_frame #(
    parameter int HALF_DIV   = 2,
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  idle,
    output logic                  frame_done,
    output logic                  sck,
    output logic                  mosi,
    output logic                  cs_n
);

    localparam int CW = $clog2(2 * HALF_DIV + 1);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF_DIV - 1);
    localparam logic [CW-1:0] GAP_M1  = CW'(2 * HALF_DIV - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    typedef enum logic [2:0] {FIDLE, FLOW, FHIGH, FHOLD, FGAP} fstate_t;

    fstate_t               state;
    logic [CW-1:0]         div_cnt;
    logic [BW-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0] shreg;
    logic                  tick;

    always_comb begin
        tick = (state == FGAP) ? (div_cnt == GAP_M1) : (div_cnt == HALF_M1);
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= FIDLE;
            div_cnt    <= '0;
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (state == FIDLE || tick) div_cnt <= '0;
            else                        div_cnt <= div_cnt + 1'b1;
            unique case (state)
                FIDLE: if (start) begin
                    shreg   <= word;
                    bit_cnt <= '0;
                    state   <= FLOW;
                end
                FLOW:  if (tick) state <= FHIGH;
                FHIGH: if (tick) begin
                    if (bit_cnt == LAST_BIT) begin
                        state <= FHOLD;
                    end else begin
                        shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= FLOW;
                    end
                end
                FHOLD: if (tick) state <= FGAP;
                FGAP:  if (tick) begin
                    frame_done <= 1'b1;
                    state      <= FIDLE;
                end
                default: state <= FIDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        idle = (state == FIDLE);
        sck  = (state == FHIGH);
        cs_n = (state == FIDLE) || (state == FGAP);
        mosi = shreg[FRAME_BITS-1];
    end

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R3

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi)); // R3

endmodule

// File: rtl/panel_spi_ctrl.sv
module panel_spi_ctrl
    import panel_spi_pkg::*;
#(
    parameter logic [15:0] MODE_MASK = 16'h3C00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [1:0]  op_kind,
    input  logic [7:0]  op_reg,
    input  logic [15:0] op_value,
    input  logic [15:0] op_mode,
    output logic        op_ready,
    output logic        busy,
    output logic        done,
    output logic        frm_start,
    output logic [23:0] frm_word,
    input  logic        frm_done,
    input  logic        frm_idle
);

    typedef enum logic [1:0] {C_IDLE, C_LOAD, C_INDEX, C_DATA} cstate_t;

    cstate_t     state;
    op_kind_t    kind_q;
    logic [7:0]  reg_q;
    logic [15:0] val_q;
    logic [15:0] mode_q;
    logic        step_q;
    logic [7:0]  cur_reg;
    logic [15:0] cur_val;
    logic        last_step;

    // register and value written at the current step of the operation
    always_comb begin
        cur_reg = reg_q;
        cur_val = val_q;
        unique case (kind_q)
            OP_WRITE: begin
                cur_reg = reg_q;
                cur_val = val_q;
            end
            OP_POWER_UP: begin
                cur_reg = step_q ? REG_DRVOUT : REG_SHUT;
                cur_val = step_q ? mode_q : SHUT_ON;
            end
            OP_RESUME: begin
                cur_reg = step_q ? REG_SHUT : REG_DRVOUT;
                cur_val = step_q ? SHUT_ON : mode_q;
            end
            OP_POWER_DOWN: begin
                cur_reg = REG_SHUT;
                cur_val = SHUT_OFF;
            end
            default: ;
        endcase
        last_step = (kind_q == OP_WRITE) || (kind_q == OP_POWER_DOWN) || step_q;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= C_IDLE;
            kind_q <= OP_WRITE;
            reg_q  <= '0;
            val_q  <= '0;
            mode_q <= '0;
            step_q <= 1'b0;
        end else begin
            unique case (state)
                C_IDLE: if (op_valid) begin
                    kind_q <= op_kind_t'(op_kind);
                    reg_q  <= op_reg;
                    val_q  <= op_value;
                    mode_q <= (DRV_BASE & ~MODE_MASK) | (op_mode & MODE_MASK);
                    step_q <= 1'b0;
                    state  <= C_LOAD;
                end
                C_LOAD:  state <= C_INDEX;
                C_INDEX: if (frm_done) state <= C_DATA;
                C_DATA:  if (frm_done) begin
                    if (last_step) begin
                        state <= C_IDLE;
                    end else begin
                        step_q <= 1'b1;
                        state  <= C_LOAD;
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    // output process
    always_comb begin
        op_ready  = (state == C_IDLE);
        busy      = (state != C_IDLE);
        done      = (state == C_DATA) && frm_done && last_step;
        frm_start = (state == C_LOAD) || ((state == C_INDEX) && frm_done);
        frm_word  = (state == C_LOAD) ? {LEAD_INDEX, 8'h00, cur_reg}
                                      : {LEAD_DATA, cur_val};
    end

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |-> frm_idle); // R2

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> busy); // R5

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> frm_idle); // R6

    AST_DONE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

endmodule

// File: rtl/panel_spi_regwr.sv
module panel_spi_regwr #(
    parameter int          HALF_DIV  = 2,
    parameter logic [15:0] MODE_MASK = 16'h3C00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    output logic        op_ready,
    input  logic [1:0]  op_kind,
    input  logic [7:0]  op_reg,
    input  logic [15:0] op_value,
    input  logic [15:0] op_mode,
    output logic        busy,
    output logic        done,
    output logic        spi_sck,
    output logic        spi_mosi,
    output logic        spi_cs_n
);

    localparam int FRAME_BITS = 24;

    logic                  frm_start;
    logic [FRAME_BITS-1:0] frm_word;
    logic                  frm_done;
    logic                  frm_idle;

    panel_spi_ctrl #(.MODE_MASK(MODE_MASK)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_kind   (op_kind),
        .op_reg    (op_reg),
        .op_value  (op_value),
        .op_mode   (op_mode),
        .op_ready  (op_ready),
        .busy      (busy),
        .done      (done),
        .frm_start (frm_start),
        .frm_word  (frm_word),
        .frm_done  (frm_done),
        .frm_idle  (frm_idle)
    );

    panel_spi_frame #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (frm_start),
        .word       (frm_word),
        .idle       (frm_idle),
        .frame_done (frm_done),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .cs_n       (spi_cs_n)
    );

endmodule

// File: tb/panel_spi_regwr_tb.sv
module panel_spi_regwr_tb;

    localparam int HALF_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_kind = 2'b00;
    logic [7:0]  op_reg = 8'h00;
    logic [15:0] op_value = 16'h0000;
    logic [15:0] op_mode = 16'h0000;
    logic        busy, done, spi_sck, spi_mosi, spi_cs_n;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int cycles = 0;
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    panel_spi_regwr #(.HALF_DIV(HALF_DIV), .MODE_MASK(16'h3C00)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_reg(op_reg), .op_value(op_value), .op_mode(op_mode),
        .busy(busy), .done(done), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // monitor: rebuild frames from the bus and compare with the scoreboard
    logic        prev_sck = 1'b0, prev_cs = 1'b1;
    logic [23:0] shift_in = '0;
    int          nbits = 0, gap = 0, frames = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (!spi_cs_n && spi_sck && !prev_sck) begin
                shift_in = {shift_in[22:0], spi_mosi};
                nbits++;
            end
            if (spi_cs_n && !prev_cs) begin
                logic [23:0] e;
                chk(nbits == 24, "R1 frame bit count", nbits, 24);
                chk(!spi_sck, "R3 sck low when deselected", {31'd0, spi_sck}, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected frame", shift_in, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(shift_in == e, "R2 frame content", shift_in, e);
                end
                frames++;
                gap = 0;
            end
            if (spi_cs_n) gap++;
            if (!spi_cs_n && prev_cs) begin
                if (frames > 0)
                    chk(gap >= 2 * HALF_DIV, "R4 deselect gap", gap, 2 * HALF_DIV);
                nbits = 0;
            end
            prev_sck = spi_sck;
            prev_cs  = spi_cs_n;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic push_write(input logic [7:0] r, input logic [15:0] v);
        exp_q.push_back({8'h74, 8'h00, r});
        exp_q.push_back({8'h76, v});
    endtask

    task automatic run_op(input logic [1:0] k, input logic [7:0] r,
                          input logic [15:0] v, input logic [15:0] m,
                          input string req, input bit poke_busy);
        int d0;
        while (!op_ready) @(negedge clk);
        d0 = done_cnt;
        op_kind = k; op_reg = r; op_value = v; op_mode = m;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        if (poke_busy) begin
            int rdy_seen = 0;
            op_kind = 2'b00; op_reg = 8'hEE; op_value = 16'hDEAD;
            op_valid = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (op_ready) rdy_seen++;
            end
            op_valid = 1'b0;
            chk(rdy_seen == 0, "R5 ready low while busy", rdy_seen, 0);
            chk(busy, "R5 busy during operation", {31'd0, busy}, 1);
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, {req, " all frames seen"}, exp_q.size(), 0);
        chk(done_cnt - d0 == 1, "R6 one done per operation", done_cnt - d0, 1);
        chk(!done && spi_cs_n, "R6 done single pulse with cs high",
            {30'd0, done, spi_cs_n}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !busy && op_ready && !done, "R12 reset state",
            {27'd0, spi_cs_n, spi_sck, busy, op_ready, done}, 5'b10010);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 plain writes, R1 / R2 framing
        push_write(8'h5A, 16'h1234);
        run_op(2'b00, 8'h5A, 16'h1234, 16'h0000, "R7 write 5A", 1'b0);
        push_write(8'hFF, 16'h00FF);
        run_op(2'b00, 8'hFF, 16'h00FF, 16'hFFFF, "R7 write FF", 1'b0);
        push_write(8'h80, 16'h8001);
        run_op(2'b00, 8'h80, 16'h8001, 16'h0000, "R7 write 80", 1'b1);

        // R8 power-up with all mode bits set, R11 merge -> 0x3EEF
        push_write(8'h11, 16'h0000);
        push_write(8'h01, 16'h3EEF);
        run_op(2'b01, 8'h00, 16'h0000, 16'hFFFF, "R8 power-up R11", 1'b0);

        // R9 resume with mode 0x1400 plus bits outside mask -> 0x16EF
        push_write(8'h01, 16'h16EF);
        push_write(8'h11, 16'h0000);
        run_op(2'b10, 8'h00, 16'h0000, 16'h5401, "R9 resume R11", 1'b1);

        // R10 power-down
        push_write(8'h11, 16'h0001);
        run_op(2'b11, 8'h33, 16'h4444, 16'h0000, "R10 power-down", 1'b0);

        // R11 mode zero -> base with mask bits cleared 0x02EF
        push_write(8'h11, 16'h0000);
        push_write(8'h01, 16'h02EF);
        run_op(2'b01, 8'h00, 16'h0000, 16'h0000, "R11 power-up mode0", 1'b0);

        repeat (50) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, "R5 no stray frames after ignored requests",
            exp_q.size(), 0);
        finish_run();
    end

endmodule